// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Unit

This unit sits between a host bus and the rest of a network adapter. The host writes 16-bit command words to a single port. The unit splits each word into a 5-bit opcode and an 11-bit argument and acts on it. Commands select the register window, turn the receiver and the transmitter on and off, load a receive address filter, load an interrupt enable mask, raise a software interrupt request, acknowledge events, and reset the whole unit.

Single-cycle pulses from the adapter's datapaths latch event flags. The unit drives one interrupt line from those flags and the enable mask. A status word, read at any time, carries the selected window, a busy flag, the latched events and the interrupt condition. The host polls the busy flag and waits for it to clear before it issues the next command.

Top module: `cmd_status_unit`

## Requirements
- R1: A command word has its opcode in bits 15:11 and its argument in bits 10:0. It is acted on in the cycle `cmdValid` is high. Argument bits a command does not use are ignored. Opcodes other than 0, 1, 3, 4, 9, 10, 12, 13, 14 and 16 change nothing.
- R2: Opcode 1 loads the window number from argument bits 2:0. The status word shows the window in bits 15:13. Status bits 11:8 always read 0.
- R3: Status bit 12 (busy) is 1 for exactly BUSY_CYCLES clock cycles after reset is released and after an accepted opcode 1 or opcode 0. A command that arrives while busy is 1 is ignored.
- R4: An event pulse on `evtIn` bit 1, 2, 3, 4, 5 or 7 sets the status bit at the same position. The flag stays set until it is acknowledged. Pulses on `evtIn` bits 0 and 6 have no effect.
- R5: Opcode 13 clears each latched status bit among bits 7:1 whose argument bit is 1. When an event pulse and its acknowledge arrive in the same cycle, the flag ends up set.
- R6: Opcode 12 sets status bit 6 (interrupt requested).
- R7: Opcode 14 loads an 8-bit enable mask from argument bits 7:0. `irqOut` is 1 while some status bit among 7:1 is both latched and enabled. Status bit 0 always equals `irqOut`.
- R8: Opcode 4 enables the receiver and opcode 3 disables it. Opcode 9 enables the transmitter and opcode 10 disables it. Both are disabled after reset.
- R9: Opcode 16 loads `rxFilter` from argument bits 3:0. The bits mean: 0 individual, 1 multicast, 2 broadcast, 3 promiscuous.
- R10: Opcode 0 returns the window, the event flags, the mask, the enables and the filter to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command word valid this cycle |
| cmdWord | input | 16 | Command word: opcode 15:11, argument 10:0 |
| evtIn | input | 8 | Event pulses, bit positions as in the status word |
| statusWord | output | 16 | Window, busy flag, event flags, interrupt condition |
| irqOut | output | 1 | Interrupt line |
| rxEnabled | output | 1 | Receiver enabled |
| txEnabled | output | 1 | Transmitter enabled |
| rxFilter | output | 4 | Receive filter setting |

## Verification
An acknowledge command and a datapath event can hit the same flag in the same cycle. This is the collision that matters. The bench lines up an acknowledge of bit 2 with an `evtIn` bit 2 pulse on the same clock edge. It expects the flag to stay set. It then sends a lone acknowledge of bit 3 to show that clearing works when no event competes. A second collision occurs when a command arrives during the busy window right after a window select. The bench drives a receiver-enable command there and expects no change on `rxEnabled`.

// File: rtl/csu_pkg.sv
`timescale 1ns/1ps
package csu_pkg;
  localparam int CMD_W  = 16;
  localparam int OP_W   = 5;
  localparam int ARG_W  = CMD_W - OP_W;
  localparam int EVT_W  = 8;
  localparam int WIN_W  = 3;
  localparam int FILT_W = 4;

  // status positions that datapath pulses may set (bits 0 and 6 are not events)
  localparam logic [EVT_W-1:0] EVT_IN_MASK = 8'hBE;
  localparam int REQ_BIT = 6;

  typedef enum logic [OP_W-1:0] {
    OP_GLOBAL_RESET = 5'd0,
    OP_SEL_WINDOW   = 5'd1,
    OP_RX_OFF       = 5'd3,
    OP_RX_ON        = 5'd4,
    OP_TX_ON        = 5'd9,
    OP_TX_OFF       = 5'd10,
    OP_REQ_INTR     = 5'd12,
    OP_ACK          = 5'd13,
    OP_SET_MASK     = 5'd14,
    OP_SET_FILTER   = 5'd16
  } opcode_e;

  typedef struct packed {
    logic              glbReset;
    logic              winLd;
    logic [WIN_W-1:0]  winVal;
    logic              rxOn;
    logic              rxOff;
    logic              txOn;
    logic              txOff;
    logic              reqIntr;
    logic              ackLd;
    logic              maskLd;
    logic [EVT_W-1:0]  argBits;
    logic              filtLd;
    logic [FILT_W-1:0] filtVal;
  } strobe_t;
endpackage

// File: rtl/csu_ctrl.sv
`timescale 1ns/1ps
module csu_ctrl
  import csu_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdWord,
  output strobe_t          strb,
  output logic             busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] BUSY_INIT = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] busyCnt;
  logic [OP_W-1:0]  opcode;
  logic             accept;
  logic             unusedArgBits;

  assign opcode        = cmdWord[CMD_W-1:ARG_W];
  assign unusedArgBits = ^cmdWord[ARG_W-1:EVT_W];
  assign busy          = (busyCnt != '0);
  assign accept        = cmdValid && !busy;

  always_comb begin
    strb         = '0;
    strb.winVal  = cmdWord[WIN_W-1:0];
    strb.argBits = cmdWord[EVT_W-1:0];
    strb.filtVal = cmdWord[FILT_W-1:0];
    if (accept) begin
      case (opcode)
        OP_GLOBAL_RESET: strb.glbReset = 1'b1;
        OP_SEL_WINDOW:   strb.winLd    = 1'b1;
        OP_RX_OFF:       strb.rxOff    = 1'b1;
        OP_RX_ON:        strb.rxOn     = 1'b1;
        OP_TX_ON:        strb.txOn     = 1'b1;
        OP_TX_OFF:       strb.txOff    = 1'b1;
        OP_REQ_INTR:     strb.reqIntr  = 1'b1;
        OP_ACK:          strb.ackLd    = 1'b1;
        OP_SET_MASK:     strb.maskLd   = 1'b1;
        OP_SET_FILTER:   strb.filtLd   = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      busyCnt <= BUSY_INIT;
    else if (strb.glbReset || strb.winLd)
      busyCnt <= BUSY_INIT;
    else if (busy)
      busyCnt <= busyCnt - 1'b1;
  end
endmodule

// File: rtl/csu_datapath.sv
`timescale 1ns/1ps
module csu_datapath
  import csu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              busy,
  input  logic [EVT_W-1:0]  evtIn,
  output logic [CMD_W-1:0]  statusWord,
  output logic              irqOut,
  output logic              rxEnabled,
  output logic              txEnabled,
  output logic [FILT_W-1:0] rxFilter
);
  logic [WIN_W-1:0] window;
  logic [EVT_W-1:0] evtLat;
  logic [EVT_W-1:0] intMask;
  logic [EVT_W-1:0] evtSet;
  logic [EVT_W-1:0] ackClr;
  logic [EVT_W-1:0] evtNext;

  assign evtSet = (evtIn & EVT_IN_MASK) | (EVT_W'(strb.reqIntr) << REQ_BIT);
  assign ackClr = strb.ackLd ? strb.argBits : '0;
  // a new event outranks an acknowledge in the same cycle
  assign evtNext = ((evtLat & ~ackClr) | evtSet) & ~EVT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      window    <= '0;
      evtLat    <= '0;
      intMask   <= '0;
      rxEnabled <= 1'b0;
      txEnabled <= 1'b0;
      rxFilter  <= '0;
    end else if (strb.glbReset) begin
      window    <= '0;
      evtLat    <= '0;
      intMask   <= '0;
      rxEnabled <= 1'b0;
      txEnabled <= 1'b0;
      rxFilter  <= '0;
    end else begin
      evtLat <= evtNext;
      if (strb.winLd)  window   <= strb.winVal;
      if (strb.maskLd) intMask  <= strb.argBits;
      if (strb.filtLd) rxFilter <= strb.filtVal;
      if (strb.rxOn)       rxEnabled <= 1'b1;
      else if (strb.rxOff) rxEnabled <= 1'b0;
      if (strb.txOn)       txEnabled <= 1'b1;
      else if (strb.txOff) txEnabled <= 1'b0;
    end
  end

  assign irqOut     = |(evtLat & intMask & ~EVT_W'(1));
  assign statusWord = {window, busy, 4'b0000, evtLat[EVT_W-1:1], irqOut};
endmodule

// File: rtl/cmd_status_unit.sv
`timescale 1ns/1ps
module cmd_status_unit
  import csu_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [15:0] cmdWord,
  input  logic [7:0]  evtIn,
  output logic [15:0] statusWord,
  output logic        irqOut,
  output logic        rxEnabled,
  output logic        txEnabled,
  output logic [3:0]  rxFilter
);
  strobe_t strb;
  logic    busy;

  csu_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .strb(strb), .busy(busy)
  );

  csu_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .evtIn(evtIn),
    .statusWord(statusWord), .irqOut(irqOut), .rxEnabled(rxEnabled),
    .txEnabled(txEnabled), .rxFilter(rxFilter)
  );
endmodule

// File: rtl/csu_checker.sv
`timescale 1ns/1ps
module csu_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [15:0] cmdWord,
  input logic [7:0]  evtIn,
  input logic [15:0] statusWord,
  input logic        irqOut,
  input logic        rxEnabled,
  input logic        txEnabled,
  input logic [3:0]  rxFilter
);
  logic accepted;
  assign accepted = cmdValid && !statusWord[12];

  p_irq_mirror_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == statusWord[0]);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[11:8] == 4'b0000);

  p_window_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && cmdWord[15:11] == 5'd1) |=> statusWord[15:13] == $past(cmdWord[2:0]));

  p_busy_after_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && cmdWord[15:11] == 5'd1) |=> statusWord[12]);

  p_ignore_when_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && statusWord[12]) |=>
      ($stable(rxEnabled) && $stable(txEnabled) && $stable(rxFilter)));

  p_event_latch_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((|(evtIn & 8'hBE)) && !(accepted && cmdWord[15:11] == 5'd0)) |=>
      ((statusWord[7:0] & $past(evtIn & 8'hBE)) == $past(evtIn & 8'hBE)));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && cmdWord[15:11] == 5'd13) |=>
      ((statusWord[7:1] & $past(cmdWord[7:1] & ~evtIn[7:1])) == 7'd0));

  p_req_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && cmdWord[15:11] == 5'd12) |=> statusWord[6]);
endmodule

bind cmd_status_unit csu_checker chk (.*);

// File: tb/tb_cmd_status_unit.sv
`timescale 1ns/1ps
module tb_cmd_status_unit;
  localparam int BUSY = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic [7:0]  evtIn = '0;
  logic [15:0] statusWord;
  logic        irqOut, rxEnabled, txEnabled;
  logic [3:0]  rxFilter;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  cmd_status_unit #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .evtIn(evtIn), .statusWord(statusWord), .irqOut(irqOut),
    .rxEnabled(rxEnabled), .txEnabled(txEnabled), .rxFilter(rxFilter)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    while (statusWord[12]) @(negedge clk);
  endtask

  task automatic sendRaw(input logic [4:0] op, input logic [10:0] arg);
    cmdValid = 1'b1;
    cmdWord  = {op, arg};
    @(negedge clk);
    cmdValid = 1'b0;
    cmdWord  = '0;
  endtask

  task automatic sendCmd(input logic [4:0] op, input logic [10:0] arg);
    waitIdle();
    sendRaw(op, arg);
  endtask

  task automatic pulseEvt(input logic [7:0] e);
    evtIn = e;
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 status in reset", statusWord, 16'h1000);
    check("R8 enables after reset", {14'd0, rxEnabled, txEnabled}, 16'd0);
    check("R9 filter after reset", {12'd0, rxFilter}, 16'd0);
    check("R7 irq after reset", {15'd0, irqOut}, 16'd0);
    rstN = 1'b1;
    repeat (BUSY - 1) @(negedge clk);
    check("R3 busy held after reset", {15'd0, statusWord[12]}, 16'd1);
    @(negedge clk);
    check("R3 busy clears after reset", {15'd0, statusWord[12]}, 16'd0);
  endtask

  task automatic testWindow();
    sendCmd(5'd1, 11'h0FD);
    check("R2 window select low bits", {13'd0, statusWord[15:13]}, 16'd5);
    check("R3 busy after window select", {15'd0, statusWord[12]}, 16'd1);
    repeat (BUSY - 1) @(negedge clk);
    check("R3 busy still held", {15'd0, statusWord[12]}, 16'd1);
    @(negedge clk);
    check("R3 busy released", {15'd0, statusWord[12]}, 16'd0);
    check("R2 reserved bits", {12'd0, statusWord[11:8]}, 16'd0);
  endtask

  task automatic testIgnoreBusy();
    sendCmd(5'd1, 11'd2);
    sendRaw(5'd4, 11'd0);
    check("R3 command ignored while busy", {15'd0, rxEnabled}, 16'd0);
    waitIdle();
    check("R3 window kept", {13'd0, statusWord[15:13]}, 16'd2);
  endtask

  task automatic testEnables();
    sendCmd(5'd4, 11'h7FF);
    check("R8 rx on", {14'd0, rxEnabled, txEnabled}, 16'b10);
    sendCmd(5'd9, 11'd0);
    check("R8 tx on", {14'd0, rxEnabled, txEnabled}, 16'b11);
    sendCmd(5'd3, 11'd0);
    check("R8 rx off", {14'd0, rxEnabled, txEnabled}, 16'b01);
    sendCmd(5'd10, 11'd0);
    check("R8 tx off", {14'd0, rxEnabled, txEnabled}, 16'b00);
  endtask

  task automatic testFilter();
    sendCmd(5'd16, 11'h7FA);
    check("R9 filter load", {12'd0, rxFilter}, 16'hA);
    sendCmd(5'd16, 11'h005);
    check("R9 filter reload", {12'd0, rxFilter}, 16'h5);
  endtask

  task automatic testEvents();
    pulseEvt(8'hFF);
    check("R4 events latched, bits 0 and 6 ignored", {8'd0, statusWord[7:0]}, 16'h00BE);
    check("R7 no irq with empty mask", {15'd0, irqOut}, 16'd0);
    sendCmd(5'd14, 11'h010);
    check("R7 irq on enabled event", {15'd0, irqOut}, 16'd1);
    check("R7 status bit0 mirrors irq", {8'd0, statusWord[7:0]}, 16'h00BF);
    sendCmd(5'd13, 11'h011);
    check("R5 ack clears bit4", {8'd0, statusWord[7:0]}, 16'h00AE);
    check("R7 irq drops after ack", {15'd0, irqOut}, 16'd0);
  endtask

  task automatic testRequest();
    sendCmd(5'd12, 11'h7FF);
    check("R6 request sets bit6", {8'd0, statusWord[7:0]}, 16'h00EE);
    sendCmd(5'd14, 11'h040);
    check("R7 irq from request", {15'd0, irqOut}, 16'd1);
    sendCmd(5'd13, 11'h040);
    check("R5 ack clears request", {8'd0, statusWord[7:0]}, 16'h00AE);
  endtask

  task automatic testCollision();
    waitIdle();
    evtIn = 8'h04;
    sendRaw(5'd13, 11'h004);
    evtIn = 8'h00;
    check("R5 event wins over same-cycle ack", {8'd0, statusWord[7:0]}, 16'h00AE);
    sendCmd(5'd13, 11'h008);
    check("R5 lone ack clears bit3", {8'd0, statusWord[7:0]}, 16'h00A6);
  endtask

  task automatic testUnknown();
    logic [15:0] snapStat;
    logic [5:0]  snapOut;
    waitIdle();
    snapStat = statusWord;
    snapOut  = {irqOut, rxEnabled, txEnabled, rxFilter[2:0]};
    sendCmd(5'd2, 11'h7FF);
    sendCmd(5'd7, 11'h7FF);
    sendCmd(5'd31, 11'h7FF);
    check("R1 unknown opcodes: status", statusWord, snapStat);
    check("R1 unknown opcodes: outputs",
          {10'd0, irqOut, rxEnabled, txEnabled, rxFilter[2:0]}, {10'd0, snapOut});
  endtask

  task automatic testGlobalReset();
    sendCmd(5'd14, 11'h0FF);
    sendCmd(5'd4, 11'd0);
    sendCmd(5'd1, 11'd6);
    sendCmd(5'd0, 11'h7FF);
    check("R10 status after global reset", statusWord, 16'h1000);
    check("R10 outputs after global reset",
          {11'd0, rxEnabled, txEnabled, rxFilter}, 16'd0);
    waitIdle();
    pulseEvt(8'h02);
    check("R10 mask cleared by global reset",
          {7'd0, irqOut, statusWord[7:0]}, 16'h0002);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testWindow();
    testIgnoreBusy();
    testEnables();
    testFilter();
    testEvents();
    testRequest();
    testCollision();
    testUnknown();
    testGlobalReset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule